// File: doc/BRIEF.md
# Hierarchical State-Enable Register Bank

This block holds the three state-enable registers that gate less-privileged access to optional architectural state. There is a 64-bit machine-level register, an optional 64-bit hypervisor-level register and a 32-bit supervisor-level register. Software reads and writes them through a CSR port addressed by the 12-bit CSR number. The block also drives the effective enable vector of each level to the access-check logic elsewhere in the core.

Each level can only show a one where every more-privileged level allows it. A write stores the write data ANDed with a static writable mask. A read returns the stored value ANDed with the live value of the levels above, so clearing a machine-level bit hides the lower copies at once. The hidden lower-level bits stay stored and come back when the machine bit is set again. The floating-point CSR enable is forced to zero while the floating-point extension is enabled (`misa_f` high). Parameters choose which bits exist at each level and whether the hypervisor level exists.

Top module: `senable_bank`

## Requirements
- R1: After reset all three registers read zero and all three effective enable outputs are zero.
- R2: The machine register is at CSR 0x30C. A write stores only the implemented bits. By default these are 63, 62, 60..54, 2, 1 and 0 (mask 0xDFC0_0000_0000_0007). Every other bit reads zero.
- R3: While `misa_f` is 1, bit 1 (the floating-point CSR enable) reads zero at the machine level, cannot be written there, and is therefore zero at the lower levels.
- R4: The hypervisor register is at 0x60C. Only bits implemented at the machine level can be written. A read returns the stored value ANDed with the current machine-level value.
- R5: The supervisor register is at 0x10C and is 32 bits wide, zero-extended on reads. By default only bits 2..0 exist. A read returns the stored value ANDed with bits 31..0 of the hypervisor and machine values.
- R6: A lower-level bit hidden by a cleared machine bit keeps its stored value and reads as one again once the machine bit is set, with no new lower-level write.
- R7: With the hypervisor level absent, 0x60C reads zero, its effective output is zero, and the supervisor register is masked by the machine value alone.
- R8: A CSR number other than the three above drives `csr_hit` low and `csr_rdata` to zero. A write to such a number changes no register.
- R9: The effective outputs `en_mach`, `en_hyp` and `en_sup` always equal what a read of the matching register returns.
- R10: Elaboration rejects a machine-level bit 63 that is not implemented while the hypervisor level exists or any supervisor bit is implemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| misa_f | input | 1 | Floating-point extension enabled |
| csr_wr_en | input | 1 | Write strobe for the addressed register |
| csr_addr | input | 12 | CSR number for read and write |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data for csr_addr, combinational |
| csr_hit | output | 1 | csr_addr selects one of the three registers |
| en_mach | output | 64 | Effective machine-level enables |
| en_hyp | output | 64 | Effective hypervisor-level enables |
| en_sup | output | 32 | Effective supervisor-level enables |

## Verification
The assertions check several properties on every cycle. Each register's stored value must follow its last write or hold. The lower-level outputs must stay inside the higher-level ones. The floating-point enable must stay zero while `misa_f` is set. Reads must match the effective outputs, and a missed address must read zero. Only the bench scenarios show the rest: that hidden bits come back after the machine bit is set again (R6), that the exact masked values come out under random write sequences and `misa_f` toggling, and that the variant without a hypervisor level behaves as R7 says.

// File: rtl/senable_pkg.sv
package senable_pkg;
   localparam int unsigned XW = 64;
   localparam int unsigned SW = 32;
   localparam int unsigned AW = 12;

   localparam logic [AW-1:0] CSR_MACH = 12'h30C;
   localparam logic [AW-1:0] CSR_HYP  = 12'h60C;
   localparam logic [AW-1:0] CSR_SUP  = 12'h10C;

   localparam int unsigned BIT_FPCSR = 1;
   localparam int unsigned BIT_TOP   = 63;

   localparam logic [XW-1:0] DEFINED_BITS = 64'hDFC0_0000_0000_0007;
endpackage

// File: rtl/senable_level.sv
module senable_level
   import senable_pkg::*;
#(
   parameter int unsigned            W    = 64,
   parameter logic [AW-1:0]          ADDR = 12'h000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   input  logic [W-1:0]  wmask,
   input  logic [W-1:0]  parent_en,
   output logic [W-1:0]  visible
);
   logic [W-1:0] q;
   logic         sel;

   assign sel = (addr == ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en && sel) begin
         q <= wdata & wmask;
      end
   end

   assign visible = q & wmask & parent_en;

   // R2 R4 R5: a write lands as data under the writable mask
   a_r2_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel) |=> (q == $past(wdata & wmask)));

   // R6 R8: without a write to this level the stored bits never move
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel) |=> (q == $past(q)));
endmodule

// File: rtl/senable_rdmux.sv
module senable_rdmux
   import senable_pkg::*;
(
   input  logic [AW-1:0] addr,
   input  logic [XW-1:0] mach_v,
   input  logic [XW-1:0] hyp_v,
   input  logic [SW-1:0] sup_v,
   output logic [XW-1:0] rdata,
   output logic          hit
);
   always_comb begin
      rdata = '0;
      hit   = 1'b1;
      unique case (addr)
         CSR_MACH: rdata = mach_v;
         CSR_HYP:  rdata = hyp_v;
         CSR_SUP:  rdata = {{(XW-SW){1'b0}}, sup_v};
         default:  hit   = 1'b0;
      endcase
   end

   // R8: a missed number never returns data
   a_r8_miss_zero: assert property (@(addr) !hit |-> (rdata == '0));
endmodule

// File: rtl/senable_bank.sv
module senable_bank
   import senable_pkg::*;
#(
   parameter bit             HYP_PRESENT = 1'b1,
   parameter logic [XW-1:0]  MACH_IMPL   = DEFINED_BITS,
   parameter logic [XW-1:0]  HYP_IMPL    = DEFINED_BITS,
   parameter logic [SW-1:0]  SUP_IMPL    = 32'h0000_0007
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          misa_f,
   input  logic          csr_wr_en,
   input  logic [AW-1:0] csr_addr,
   input  logic [XW-1:0] csr_wdata,
   output logic [XW-1:0] csr_rdata,
   output logic          csr_hit,
   output logic [XW-1:0] en_mach,
   output logic [XW-1:0] en_hyp,
   output logic [SW-1:0] en_sup
);
   localparam logic [XW-1:0] HYP_WMASK = HYP_PRESENT ? (HYP_IMPL & MACH_IMPL) : '0;
   localparam logic [SW-1:0] SUP_WMASK = SUP_IMPL & MACH_IMPL[SW-1:0]
                                         & (HYP_PRESENT ? HYP_IMPL[SW-1:0] : '1);
   localparam logic [XW-1:0] FP_BIT    = XW'(1) << BIT_FPCSR;

   // R10: the top machine bit may only be absent with no hypervisor and no supervisor bits
   generate
      if (!MACH_IMPL[BIT_TOP] && (HYP_PRESENT || (SUP_IMPL != '0))) begin : g_bad_top
         $error("senable_bank: machine bit 63 must be implemented for this configuration");
      end
   endgenerate

   logic [XW-1:0] mach_wmask;
   logic [XW-1:0] mach_v;
   logic [XW-1:0] hyp_v;
   logic [SW-1:0] sup_v;
   logic [SW-1:0] sup_parent;

   assign mach_wmask = MACH_IMPL & ~(misa_f ? FP_BIT : '0);

   senable_level #(.W(XW), .ADDR(CSR_MACH)) i_mach (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (csr_wr_en),
      .addr      (csr_addr),
      .wdata     (csr_wdata),
      .wmask     (mach_wmask),
      .parent_en ({XW{1'b1}}),
      .visible   (mach_v)
   );

   generate
      if (HYP_PRESENT) begin : g_hyp
         senable_level #(.W(XW), .ADDR(CSR_HYP)) i_hyp (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (csr_wr_en),
            .addr      (csr_addr),
            .wdata     (csr_wdata),
            .wmask     (HYP_WMASK),
            .parent_en (mach_v),
            .visible   (hyp_v)
         );
         assign sup_parent = hyp_v[SW-1:0];
      end else begin : g_no_hyp
         assign hyp_v      = '0;
         assign sup_parent = mach_v[SW-1:0];
      end
   endgenerate

   senable_level #(.W(SW), .ADDR(CSR_SUP)) i_sup (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (csr_wr_en),
      .addr      (csr_addr),
      .wdata     (csr_wdata[SW-1:0]),
      .wmask     (SUP_WMASK),
      .parent_en (sup_parent),
      .visible   (sup_v)
   );

   senable_rdmux i_rdmux (
      .addr   (csr_addr),
      .mach_v (mach_v),
      .hyp_v  (hyp_v),
      .sup_v  (sup_v),
      .rdata  (csr_rdata),
      .hit    (csr_hit)
   );

   assign en_mach = mach_v;
   assign en_hyp  = hyp_v;
   assign en_sup  = sup_v;

   // R3: floating-point CSR enable is zero while misa_f is set
   a_r3_fp_forced: assert property (@(posedge clk) disable iff (!rst_n)
      misa_f |-> !en_mach[BIT_FPCSR]);

   // R4: hypervisor enables lie inside machine enables
   a_r4_hyp_inside: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_hyp & ~en_mach) == '0));

   // R5: supervisor enables lie inside both higher levels
   a_r5_sup_inside: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_sup & ~en_mach[SW-1:0]) == '0) && (!HYP_PRESENT || ((en_sup & ~en_hyp[SW-1:0]) == '0)));

   // R7: no hypervisor level means nothing at its output
   a_r7_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
      HYP_PRESENT || (en_hyp == '0));

   // R9: reads agree with the effective outputs
   a_r9_read_match: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr == CSR_MACH) |-> (csr_hit && (csr_rdata == en_mach)));
endmodule

// File: tb/test_senable_bank.sv
module test_senable_bank;
   import senable_pkg::*;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned WATCHDOG   = 20000;
   localparam logic [63:0] MI         = 64'hDFC0_0000_0000_0007;
   localparam logic [31:0] SI         = 32'h0000_0007;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          misa_f = 1'b0;
   logic          wr_en = 1'b0;
   logic [11:0]   addr = 12'h000;
   logic [63:0]   wdata = '0;
   logic [63:0]   rdata, rdata_n;
   logic          hit, hit_n;
   logic [63:0]   em, eh, em_n, eh_n;
   logic [31:0]   es, es_n;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [63:0] m_st, h_st, nm_st;
   logic [31:0] s_st, ns_st;

   always #(CLK_PERIOD/2) clk = ~clk;

   senable_bank i_senable_bank (
      .clk(clk), .rst_n(rst_n), .misa_f(misa_f), .csr_wr_en(wr_en),
      .csr_addr(addr), .csr_wdata(wdata), .csr_rdata(rdata), .csr_hit(hit),
      .en_mach(em), .en_hyp(eh), .en_sup(es));

   senable_bank #(.HYP_PRESENT(1'b0)) i_senable_bank_nohyp (
      .clk(clk), .rst_n(rst_n), .misa_f(misa_f), .csr_wr_en(wr_en),
      .csr_addr(addr), .csr_wdata(wdata), .csr_rdata(rdata_n), .csr_hit(hit_n),
      .en_mach(em_n), .en_hyp(eh_n), .en_sup(es_n));

   function automatic logic [63:0] mwm(input logic f);
      return MI & ~(f ? 64'h2 : 64'h0);
   endfunction
   function automatic logic [63:0] mvis(input logic [63:0] st, input logic f);
      return st & mwm(f);
   endfunction
   function automatic logic [63:0] hvis(input logic [63:0] st, input logic [63:0] mv);
      return st & MI & mv;
   endfunction
   function automatic logic [31:0] svis(input logic [31:0] st, input logic [31:0] par);
      return st & SI & par;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk);
      if (a == CSR_MACH) begin m_st = d & mwm(misa_f); nm_st = d & mwm(misa_f); end
      if (a == CSR_HYP)  h_st = d & MI;
      if (a == CSR_SUP)  begin s_st = d[31:0] & SI; ns_st = d[31:0] & SI; end
      #1 wr_en = 1'b0;
   endtask

   task automatic check_all(input string tag);
      logic [63:0] mv, hv, nmv;
      logic [31:0] sv, nsv;
      mv  = mvis(m_st, misa_f);
      hv  = hvis(h_st, mv);
      sv  = svis(s_st, hv[31:0]);
      nmv = mvis(nm_st, misa_f);
      nsv = svis(ns_st, nmv[31:0]);
      @(negedge clk);
      addr = CSR_MACH; #1;
      chk({tag, " R2 mach read"}, rdata, mv);
      chk({tag, " R8 mach hit"}, {63'd0, hit}, 64'd1);
      addr = CSR_HYP; #1;
      chk({tag, " R4 hyp read"}, rdata, hv);
      chk({tag, " R7 nohyp hyp read"}, rdata_n, 64'd0);
      addr = CSR_SUP; #1;
      chk({tag, " R5 sup read"}, rdata, {32'd0, sv});
      chk({tag, " R7 nohyp sup read"}, rdata_n, {32'd0, nsv});
      chk({tag, " R9 en_mach"}, em, mv);
      chk({tag, " R9 en_hyp"}, eh, hv);
      chk({tag, " R9 en_sup"}, {32'd0, es}, {32'd0, sv});
      chk({tag, " R7 nohyp en_hyp"}, eh_n, 64'd0);
      chk({tag, " R7 nohyp en_sup"}, {32'd0, es_n}, {32'd0, nsv});
      chk({tag, " R3 fp bit"}, {63'd0, em[1]}, {63'd0, mv[1]});
   endtask

   initial begin
      int unsigned seed;
      for (int i = 0; i < WATCHDOG; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unsigned sd;
      logic [11:0] pick [4];
      sd = $urandom(32'h5EED_0042);
      pick[0] = CSR_MACH; pick[1] = CSR_HYP; pick[2] = CSR_SUP; pick[3] = 12'h7C0;
      m_st = '0; h_st = '0; s_st = '0; nm_st = '0; ns_st = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      check_all("R1 reset");
      chk("R1 en_mach zero", em, 64'd0);

      // R2: all-ones write keeps only implemented bits
      wr(CSR_MACH, '1);
      check_all("R2 ones");
      chk("R2 mach mask", em, MI);
      wr(CSR_HYP, '1);
      wr(CSR_SUP, '1);
      check_all("R4 R5 ones");
      chk("R5 sup bits", {32'd0, es}, 64'h7);

      // R3: misa_f hides and blocks the floating-point CSR enable
      @(negedge clk) misa_f = 1'b1;
      check_all("R3 f on");
      chk("R3 sup bit1 hidden", {32'd0, es}, 64'h5);
      wr(CSR_MACH, '1);
      @(negedge clk) misa_f = 1'b0;
      check_all("R3 f off after write");
      chk("R3 bit1 not stored", {63'd0, em[1]}, 64'd0);

      // R6: clearing machine hides, restoring reveals stored lower bits
      wr(CSR_MACH, '0);
      check_all("R6 mach cleared");
      chk("R6 hyp hidden", eh, 64'd0);
      wr(CSR_MACH, '1);
      check_all("R6 mach restored");
      chk("R6 hyp back", eh, MI);
      chk("R6 sup back", {32'd0, es}, 64'h7);

      // R8: unknown number: no hit, zero data, nothing changes
      wr(12'h7C0, 64'h0);
      @(negedge clk) addr = 12'h7C0; #1;
      chk("R8 miss hit", {63'd0, hit}, 64'd0);
      chk("R8 miss data", rdata, 64'd0);
      check_all("R8 after stray write");

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [63:0] d;
         d = {$urandom, $urandom};
         if (($urandom % 8) == 0) begin
            @(negedge clk) misa_f = ~misa_f;
         end
         wr(pick[$urandom % 4], d);
         if ((n % 10) == 0) check_all("random R2 R4 R5 R6");
      end
      check_all("random end");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule